// File: doc/BRIEF.md
# Frame-Synchronised Serial Register Write Port

This block is a slave port that turns a serial bit stream into writes on a parallel internal register bus. The serial clock runs all the time. A transfer starts only when a frame-sync pulse is seen on a falling clock edge. Data bits are taken on rising edges and grouped into bytes. A static input selects whether each byte arrives most significant bit first or least significant bit first.

Each frame starts with a two-byte header. The first byte is the start address. The second byte holds a read/write flag and a 7-bit block count. When the flag marks a write, every byte that follows produces one write strobe. The first data byte goes to the start address, and each later byte goes to the next address up. The frame ends after count plus one data bytes. After that the port stays idle until the next frame sync. A frame sync that arrives in the middle of a frame drops the frame in progress and starts a new header.

Top module: `fcp_slave`

## Requirements
- R1: While reset is asserted, and after it is released, `wr_en` is low and `wr_addr` and `wr_data` are zero. Reset is asynchronous when asserted and synchronous when released.
- R2: `frame_sync` is sampled on the falling edge of `ser_clk`. The first header bit is captured on the next rising edge. While the port is idle, `ser_din` has no effect unless a frame sync is seen.
- R3: When `bit_order_msb` is 1, the first bit of each byte on the wire is bit 7 of that byte.
- R4: When `bit_order_msb` is 0, the first bit of each byte on the wire is bit 0 of that byte.
- R5: The first byte of a frame is the start address. In the second byte, the flag is the first bit on the wire: bit 7 in MSB-first order, bit 0 in LSB-first order. The other seven bits form the count, in the same significance order as the byte. A flag of 0 means write and 1 means read.
- R6: Each data byte in a write frame raises `wr_en` for exactly one cycle, on the rising edge that captures the byte's eighth bit. `wr_data` carries the byte. `wr_addr` starts at the start address and increases by one for each write, wrapping modulo 2^ADDR_W.
- R7: A write frame produces exactly count+1 writes. After that the port is idle, and further bits without a frame sync produce no writes.
- R8: A frame whose flag is 1 produces no writes, and its data bytes are discarded.
- R9: A frame sync seen during a frame drops any partly received byte and restarts header reception. Writes already issued stand. The edge that restarts the frame produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Continuously running serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame start pulse, sampled on the falling clock edge |
| ser_din | input | 1 | Serial data, sampled on the rising clock edge |
| bit_order_msb | input | 1 | 1 = MSB first, 0 = LSB first; held static within a frame |
| wr_en | output | 1 | One-cycle internal write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data byte |

## Verification
The assertions assume three things about the inputs. `frame_sync` is high for a single falling edge at the start of each frame. `bit_order_msb` changes only while no frame is in progress. Both serial inputs settle well away from the clock edges. The stimulus meets these conditions: it changes every input in the middle of the clock's high phase, raises frame sync only together with the first header bit, and switches bit order only between frames. Restart-aware address checking depends on an aborting frame sync always starting a full new header, and the bench's abort cases are built that way.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = BYTE_W - 1;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HDR,
    ST_DATA,
    ST_SKIP
  } fcp_state_e;
endpackage

// File: rtl/fcp_rst_sync.sv
module fcp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/fcp_fsync_sampler.sv
module fcp_fsync_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_in,
  output logic fsync_seen
);
  logic seen_q;

  // frame sync is captured on the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= fsync_in;
  end

  assign fsync_seen = seen_q;
endmodule

// File: rtl/fcp_byte_shifter.sv
module fcp_byte_shifter
  import fcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              din,
  input  logic              msb_first,
  output logic [BYTE_W-1:0] byte_val,
  output logic              byte_done
);
  logic [BYTE_W-1:0]    sh_q, sh_d;
  logic [BIT_IDX_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-1:0]    assembled;

  // bit-order dependent assembly of the incoming bit
  always_comb begin
    if (msb_first) assembled = {sh_q[BYTE_W-2:0], din};
    else           assembled = {din, sh_q[BYTE_W-1:1]};
  end

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (run) begin
      sh_d  = assembled;
      cnt_d = restart ? BIT_IDX_W'(1) : cnt_q + BIT_IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (run) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign byte_val  = assembled;
  assign byte_done = run && !restart && (cnt_q == BIT_IDX_W'(BYTE_W - 1));
endmodule

// File: rtl/fcp_frame_ctrl.sv
module fcp_frame_ctrl
  import fcp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              msb_first,
  output fcp_state_e        state,
  output logic              run,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  fcp_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic              wen_q, wen_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;

  logic              hdr_read;
  logic [CNT_W-1:0]  hdr_cnt;
  logic              last_byte;

  // flag is the first bit on the wire, so its position follows the bit order
  always_comb begin
    if (msb_first) begin
      hdr_read = byte_val[BYTE_W-1];
      hdr_cnt  = byte_val[BYTE_W-2:0];
    end else begin
      hdr_read = byte_val[0];
      hdr_cnt  = byte_val[BYTE_W-1:1];
    end
  end

  assign last_byte = (remain_q == '0);

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    wen_d    = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    if (restart) begin
      st_d = ST_ADDR;
    end else if (byte_done) begin
      unique case (st_q)
        ST_ADDR: begin
          addr_d = ADDR_W'(byte_val);
          st_d   = ST_HDR;
        end
        ST_HDR: begin
          remain_d = hdr_cnt;
          st_d     = hdr_read ? ST_SKIP : ST_DATA;
        end
        ST_DATA: begin
          wen_d    = 1'b1;
          waddr_d  = addr_q;
          wdata_d  = byte_val;
          addr_d   = addr_q + ADDR_W'(1);
          remain_d = remain_q - CNT_W'(1);
          if (last_byte) st_d = ST_IDLE;
        end
        ST_SKIP: begin
          remain_d = remain_q - CNT_W'(1);
          if (last_byte) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      wen_q    <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      st_q     <= st_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      wen_q    <= wen_d;
      if (wen_d) begin
        waddr_q <= waddr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign state   = st_q;
  assign run     = restart || (st_q != ST_IDLE);
  assign wr_en   = wen_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
endmodule

// File: rtl/fcp_slave.sv
module fcp_slave
  import fcp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              ser_clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              ser_din,
  input  logic              bit_order_msb,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic              rst_sync_n;
  logic              fs_smp;
  logic              run;
  logic [BYTE_W-1:0] byte_val;
  logic              byte_done;
  fcp_state_e        ctrl_state;

  fcp_rst_sync rst_i (
    .clk       (ser_clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  fcp_fsync_sampler fs_i (
    .clk        (ser_clk),
    .rst_n      (rst_sync_n),
    .fsync_in   (frame_sync),
    .fsync_seen (fs_smp)
  );

  fcp_byte_shifter sh_i (
    .clk       (ser_clk),
    .rst_n     (rst_sync_n),
    .run       (run),
    .restart   (fs_smp),
    .din       (ser_din),
    .msb_first (bit_order_msb),
    .byte_val  (byte_val),
    .byte_done (byte_done)
  );

  fcp_frame_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (ser_clk),
    .rst_n     (rst_sync_n),
    .restart   (fs_smp),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .msb_first (bit_order_msb),
    .state     (ctrl_state),
    .run       (run),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );
endmodule

// File: rtl/fcp_slave_chk.sv
module fcp_slave_chk
  import fcp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_smp,
  input fcp_state_e        st,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (fs_smp) begin
      have_prev <= 1'b0;
    end else if (wr_en) begin
      have_prev <= 1'b1;
      prev_addr <= wr_addr;
    end
  end

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && have_prev && !fs_smp) |-> (wr_addr == prev_addr + ADDR_W'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !fs_smp) |=> (st == ST_IDLE && !wr_en));

  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |=> !wr_en);

  // R9
  restart_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_smp |=> (st == ST_ADDR && !wr_en));
endmodule

bind fcp_slave fcp_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (ser_clk),
  .rst_n   (rst_sync_n),
  .fs_smp  (fs_smp),
  .st      (ctrl_state),
  .wr_en   (wr_en),
  .wr_addr (wr_addr)
);

// File: tb/fcp_slave_tb_top.sv
module fcp_slave_tb_top;
  logic       clk;
  logic       rst_n;
  logic       frame_sync;
  logic       ser_din;
  logic       bit_order_msb;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  int         total = 0;
  int         bad   = 0;
  string      cur_req = "R1";
  logic [15:0] exp_q[$];

  fcp_slave #(.ADDR_W(8)) dut_i (
    .ser_clk       (clk),
    .rst_n         (rst_n),
    .frame_sync    (frame_sync),
    .ser_din       (ser_din),
    .bit_order_msb (bit_order_msb),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each strobe with the scoreboard head
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (rst_n && wr_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected write addr/data",
                int'({wr_addr, wr_data}), 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, cur_req, "write addr/data",
                int'({wr_addr, wr_data}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic drive_bit(input logic b, input logic fs);
    @(posedge clk);
    #2;
    ser_din    = b;
    frame_sync = fs;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic fs_first);
    for (int i = 0; i < 8; i++) begin
      drive_bit(bit_order_msb ? v[7-i] : v[i], fs_first && (i == 0));
    end
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) drive_bit(v[i], 1'b0);
  endtask

  // header byte built from R5: flag is the first bit on the wire
  function automatic logic [7:0] hdr(input logic [6:0] cnt, input logic rd);
    return bit_order_msb ? {rd, cnt} : {cnt, rd};
  endfunction

  task automatic send_frame(input logic [7:0] addr, input logic [6:0] cnt,
                            input logic rd, input logic [7:0] seed,
                            input int nbytes);
    send_byte(addr, 1'b1);
    send_byte(hdr(cnt, rd), 1'b0);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 37);
      if (!rd && i <= int'(cnt)) exp_q.push_back({addr + 8'(i), d});
      send_byte(d, 1'b0);
    end
  endtask

  task automatic drain(input string req);
    drive_bit(1'b0, 1'b0);
    repeat (12) @(posedge clk);
    #3;
    check(exp_q.size() == 0, req, "pending writes", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    frame_sync = 1'b0;
    ser_din = 1'b0;
    bit_order_msb = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    // R1 reset state
    check(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
    check(wr_addr == 8'h00, "R1", "wr_addr in reset", wr_addr, 0);
    check(wr_data == 8'h00, "R1", "wr_data in reset", wr_data, 0);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #3;
    check(wr_en == 1'b0, "R1", "wr_en after release", wr_en, 0);

    // R2 idle noise without frame sync
    cur_req = "R2";
    send_bits(8'hA5, 8);
    send_bits(8'h3C, 8);
    send_bits(8'hFF, 8);
    drain("R2");

    // R3 MSB first
    cur_req = "R3";
    bit_order_msb = 1'b1;
    send_frame(8'h10, 7'd2, 1'b0, 8'h81, 3);
    drain("R3");

    // R4 LSB first
    cur_req = "R4";
    bit_order_msb = 1'b0;
    send_frame(8'h22, 7'd4, 1'b0, 8'h17, 5);
    drain("R4");

    // R5 flag position: LSB order with count bit 6 set, MSB order with count bit 0 set
    cur_req = "R5";
    send_frame(8'h80, 7'h41, 1'b0, 8'h05, 66);
    drain("R5");
    bit_order_msb = 1'b1;
    send_frame(8'h44, 7'd1, 1'b0, 8'hC3, 2);
    drain("R5");

    // R6 address wrap
    cur_req = "R6";
    send_frame(8'hFD, 7'd3, 1'b0, 8'h60, 4);
    drain("R6");

    // R7 count zero then trailing bits, and maximum count
    cur_req = "R7";
    send_frame(8'h05, 7'd0, 1'b0, 8'h9E, 3);
    send_bits(8'h55, 8);
    drain("R7");
    send_frame(8'h00, 7'd127, 1'b0, 8'h01, 129);
    drain("R7");

    // R8 read frames discard data, both orders
    cur_req = "R8";
    send_frame(8'h50, 7'd3, 1'b1, 8'h77, 4);
    drain("R8");
    bit_order_msb = 1'b0;
    send_frame(8'h51, 7'd2, 1'b1, 8'h12, 3);
    drain("R8");

    // R9 abort during data, then during header
    cur_req = "R9";
    bit_order_msb = 1'b1;
    send_frame(8'h30, 7'd5, 1'b0, 8'h20, 2);
    send_bits(8'h07, 3);
    send_frame(8'h40, 7'd1, 1'b0, 8'hA0, 2);
    drain("R9");
    send_byte(8'h90, 1'b1);
    send_bits(8'h0F, 4);
    send_frame(8'h60, 7'd0, 1'b0, 8'h3B, 1);
    drain("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule